// File: doc/BRIEF.md
# Half-Bit-Tick Serial Transmitter

This block sends one 8-bit or 9-bit word at a time on a single serial line, framed by a low start bit and a high stop bit. Bit timing comes from a divider that produces a tick every half bit period. The divider runs only while a frame is being sent. It is cleared and stopped whenever the transmitter is idle.

Each tick advances a tick counter. The line moves to its next level only when that counter reaches an even value, so every bit spans two ticks. A caller presents a word, picks the word length and pulses a write strobe while the done flag is high. The done flag stays low until the stop bit has run its full length. The divider reload value is the clock frequency divided by twice the baud rate. For example, 9600 baud gives a bit of about 104 µs and a half-bit tick of about 52 µs.

Top module: `ht_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `tx` is 1 and `tx_done` is 1.
- R2: A `wr_stb` sampled high while `tx_done` is 1 is accepted. From the next cycle `tx` is 0 (start bit) and `tx_done` is 0.
- R3: Every bit of a frame holds `tx` for exactly 2·H clock cycles, where H = CLK_HZ/(2·BAUD). `tx` changes only when the internal tick count is even.
- R4: With `nine_bit` = 0, bits `wr_data[7:0]` follow the start bit, least significant bit first. Value 0x55 therefore gives 1,0,1,0,1,0,1,0.
- R5: With `nine_bit` = 1, bits `wr_data[8:0]` follow the start bit, least significant bit first, so `wr_data[8]` is the last data bit.
- R6: After the last data bit, `tx` is 1 for one full bit time (stop bit).
- R7: `tx_done` returns to 1 exactly 2·H·(N+2) cycles after acceptance, where N is 8 or 9. The next frame may be accepted in that same cycle.
- R8: A `wr_stb` that arrives while a frame is in flight is ignored, together with any change on `wr_data` or `nine_bit`. The frame on `tx` continues unchanged.
- R9: The half-bit divider produces no tick while idle and restarts from zero on acceptance. The start bit therefore lasts exactly 2·H cycles, however long the line was idle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Send request, one cycle |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| tx | output | 1 | Serial line, idle high |
| tx_done | output | 1 | High when idle and ready for a request |

## Verification
A wrong tick count or divider phase shows at the ports as a bit edge that comes early or late. It appears within the first bit time after acceptance and shifts every later bit, so the bench compares `tx` against the expected level on every cycle of every frame. A wrong bit index or wrong length mode shows as a level error in the data field, or as a stop bit or `tx_done` rise one bit time early or late. A restart on a strobe that should be ignored shows as an early low level within one cycle.

// File: rtl/uart_ht_pkg.sv
package uart_ht_pkg;

    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = MAX_DATA + 2;
    localparam int TCNT_W   = $clog2(2 * FRAME_W + 1);
    localparam int LAST_W   = TCNT_W - 1;

    typedef enum logic {
        LEN8 = 1'b0,
        LEN9 = 1'b1
    } len_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // bit 0 = start, then data LSB first, then stop
        logic [LAST_W-1:0]  last;  // index of the stop bit
    } frame_t;

    function automatic frame_t build_frame(input logic [MAX_DATA-1:0] d, input len_e len);
        frame_t f;
        if (len == LEN9) begin
            f.bits = {1'b1, d, 1'b0};
            f.last = LAST_W'(MAX_DATA + 1);
        end else begin
            f.bits = {2'b11, d[MAX_DATA-2:0], 1'b0};
            f.last = LAST_W'(MAX_DATA);
        end
        return f;
    endfunction

endpackage

// File: rtl/ht_half_tick.sv
module ht_half_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DW-1:0] TOP = DW'(HALF_CYC - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
        end else if (div_q == TOP) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = en && (div_q == TOP);

    // R9
    no_idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);

    // R9
    div_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (div_q == '0));

endmodule

// File: rtl/ht_frame_seq.sv
module ht_frame_seq
    import uart_ht_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [MAX_DATA-1:0] wr_data,
    input  len_e                len,
    input  logic                tick,
    output logic                busy,
    output logic                tx
);
    logic              busy_q;
    logic              tx_q;
    logic [TCNT_W-1:0] cnt_q;
    frame_t            frame_q;
    logic [TCNT_W-1:0] nxt;
    logic [TCNT_W-1:0] end_cnt;

    assign nxt     = cnt_q + 1'b1;
    assign end_cnt = {frame_q.last + LAST_W'(1), 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            tx_q    <= 1'b1;
            cnt_q   <= '0;
            frame_q <= '0;
        end else if (!busy_q) begin
            if (wr_stb) begin
                busy_q  <= 1'b1;
                tx_q    <= 1'b0;
                cnt_q   <= '0;
                frame_q <= build_frame(wr_data, len);
            end
        end else if (tick) begin
            if (nxt == end_cnt) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
                tx_q   <= 1'b1;
            end else begin
                cnt_q <= nxt;
                if (!nxt[0]) begin
                    tx_q <= frame_q.bits[nxt[TCNT_W-1:1]];
                end
            end
        end
    end

    assign busy = busy_q;
    assign tx   = tx_q;

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> tx_q);

    // R3
    even_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !$stable(tx_q)) |-> !cnt_q[0]);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < end_cnt));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && wr_stb && !tick) |=> (busy_q && $stable(cnt_q) && $stable(tx_q)));

endmodule

// File: rtl/ht_uart_tx.sv
module ht_uart_tx
    import uart_ht_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic                nine_bit,
    output logic                tx,
    output logic                tx_done
);
    localparam int HALF_CYC = (CLK_HZ / (2 * BAUD) > 0) ? CLK_HZ / (2 * BAUD) : 1;

    logic busy;
    logic tick;

    ht_half_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .tick (tick)
    );

    ht_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .len     (len_e'(nine_bit)),
        .tick    (tick),
        .busy    (busy),
        .tx      (tx)
    );

    assign tx_done = !busy;

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && wr_stb) |=> (!tx_done && !tx));

    // R6
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> tx);

endmodule

// File: tb/ht_uart_tx_test.sv
module ht_uart_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 600;
    localparam int BAUD       = 100;
    localparam int H          = CLK_HZ / (2 * BAUD);
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       nine_bit = 1'b0;
    logic       tx;
    logic       tx_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    ht_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .nine_bit(nine_bit), .tx(tx), .tx_done(tx_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL R7 watchdog expired: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check2(input string tag, input int j, input logic a_tx, input logic a_d,
                          input logic e_tx, input logic e_d);
        checks++;
        if (a_tx !== e_tx || a_d !== e_d) begin
            errors++;
            $display("FAIL %s cycle %0d: actual tx=%b done=%b expected tx=%b done=%b",
                     tag, j, a_tx, a_d, e_tx, e_d);
        end
    endtask

    // Sends one frame, checking tx and tx_done on every cycle until done returns.
    task automatic run_frame(input logic [8:0] d, input logic nine_i, input int gap,
                             input bit poke, input string pre);
        int nbits;
        int total;
        repeat (gap) @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        nine_bit = nine_i;
        @(posedge clk);
        nbits = nine_i ? 9 : 8;
        total = 2 * H * (nbits + 2);
        for (int j = 1; j <= total + 1; j++) begin
            int k;
            logic e_tx;
            string tag;
            @(negedge clk);
            if (j == 1) wr_stb = 1'b0;
            if (poke && j == 5) begin
                wr_stb = 1'b1;
                wr_data = ~d;
                nine_bit = ~nine_i;
            end
            if (poke && j == 6) wr_stb = 1'b0;
            if (j == total + 1) begin
                check2({pre, "R7"}, j, tx, tx_done, 1'b1, 1'b1);
            end else begin
                k = (j - 1) / (2 * H);
                if (k == 0) begin
                    e_tx = 1'b0; tag = "R2/R3";
                end else if (k <= nbits) begin
                    e_tx = d[k-1]; tag = nine_i ? "R5/R3" : "R4/R3";
                end else begin
                    e_tx = 1'b1; tag = "R6/R3";
                end
                check2({pre, tag}, j, tx, tx_done, e_tx, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check2("R1", i, tx, tx_done, 1'b1, 1'b1);
        end
        // R4: all 8-bit values, back to back
        for (int v = 0; v < 256; v++) run_frame(9'(v), 1'b0, 0, 1'b0, "");
        // R5: all 9-bit values
        for (int v = 0; v < 512; v++) run_frame(9'(v), 1'b1, 0, 1'b0, "");
        // R8: strobe and input changes during a frame
        for (int v = 0; v < 16; v++) run_frame(9'(v * 29 + 3), v[0], 1, 1'b1, "R8 ");
        // R9: various idle gaps before the request
        for (int g = 1; g < 12; g++) run_frame(9'h155 ^ 9'(g), g[0], g, 1'b0, "R9 ");
        // R1: idle again after last frame
        repeat (7) @(negedge clk);
        check2("R1", 0, tx, tx_done, 1'b1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule